// File: doc/BRIEF.md
# Thermometer Code Decoder with Bubble Flag

This block turns a 12-bit thermometer word into a 4-bit level count. A well-formed word has a solid run of ones beginning at bit 0 and zeros everywhere above the run. The level reported is the length of that run, from 0 up to 12. The block has no clock and no state, so both outputs follow the input within the same evaluation.

Any word that breaks the rule is treated as corrupt and raises a bubble flag. Corrupt words include a hole inside the run, ones sitting above zeros, and a lone high bit. While the flag is up, the level output holds full scale (12). No attempt is made to guess a nearby valid level. Downstream logic can gate on the flag, or accept the saturated value as a safe upper bound.

Top module: `tcd_thermo_decoder`

## Requirements
- R1: When the input has its lowest N bits set and every higher bit clear (N = 0..12), `level_out` equals N. All zeros gives 0, and all ones gives 12 (binary 1100).
- R2: For each of the 13 well-formed words, `bubble_err` is 0.
- R3: For any input in which some bit i+1 is 1 while bit i is 0, `bubble_err` is 1. This covers holes inside the run and ones above zeros.
- R4: A single set bit at a position above 0, with all lower bits clear, raises `bubble_err`. An example is an input of only bit 4 set.
- R5: While `bubble_err` is 1, `level_out` is 12 (binary 1100), regardless of how many bits are set or where they are.
- R6: `level_out` never takes the values 13, 14 or 15.
- R7: The block is purely combinational. Both outputs reflect a new input without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| therm_in | input | 12 | Thermometer-coded input word, bit 0 is the lowest level |
| level_out | output | 4 | Binary level count, or 12 when the word is corrupt |
| bubble_err | output | 1 | High when the input is not a well-formed thermometer word |

## Verification
The hardest words to get right are those that look almost valid. Examples are a lone high bit, a single hole just under the top of a long run, or a run that is full at the top but hollow at the bottom. In these words the highest set bit or the population count points at a plausible level, so a decoder that relies on either alone would hide the error. The stimulus first walks a table that places such near-miss words next to all 13 valid ones. It then sweeps every one of the 4096 input values against a reference model that checks adjacent bit pairs. Each word is held between clock edges and sampled with no edge in between, so the sweep also shows that the outputs follow the input without a clock.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  // Width of the thermometer word handled by this decoder family.
  localparam int TCD_W = 12;

  // Bits needed to count 0..w inclusive.
  function automatic int tcd_level_bits(input int w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/tcd_gap_detect.sv
// Flags any adjacent bit pair where the upper bit is set and the lower is clear.
module tcd_gap_detect #(
  parameter int W = 12
) (
  input  logic [W-1:0] word_i,
  output logic         gap_o
);
  logic [W-2:0] pair_bad;

  for (genvar i = 0; i < W - 1; i++) begin : g_pair
    assign pair_bad[i] = word_i[i+1] & ~word_i[i];
  end

  assign gap_o = |pair_bad;
endmodule

// File: rtl/tcd_top_index.sv
// Level = position of highest set bit plus one (0 when the word is empty).
// Equals the run length whenever the word is well formed.
module tcd_top_index #(
  parameter int W  = 12,
  parameter int OW = 4
) (
  input  logic [W-1:0]  word_i,
  output logic [OW-1:0] level_o
);
  always_comb begin
    level_o = '0;
    for (int i = 0; i < W; i++) begin
      if (word_i[i]) level_o = OW'(i + 1);
    end
  end
endmodule

// File: rtl/tcd_out_select.sv
// Saturates the level to full scale when the word is corrupt.
module tcd_out_select #(
  parameter int W  = 12,
  parameter int OW = 4
) (
  input  logic [OW-1:0] level_i,
  input  logic          gap_i,
  output logic [OW-1:0] level_o,
  output logic          err_o
);
  localparam logic [OW-1:0] FULL = OW'(W);

  always_comb begin
    err_o   = gap_i;
    level_o = gap_i ? FULL : level_i;
  end
endmodule

// File: rtl/tcd_thermo_decoder.sv
module tcd_thermo_decoder #(
  parameter int W  = tcd_pkg::TCD_W,
  localparam int OW = tcd_pkg::tcd_level_bits(W)
) (
  input  logic [W-1:0]  therm_in,
  output logic [OW-1:0] level_out,
  output logic          bubble_err
);
  logic          gap;
  logic [OW-1:0] raw_level;

  tcd_gap_detect #(.W(W)) u_gap (
    .word_i (therm_in),
    .gap_o  (gap)
  );

  tcd_top_index #(.W(W), .OW(OW)) u_idx (
    .word_i  (therm_in),
    .level_o (raw_level)
  );

  tcd_out_select #(.W(W), .OW(OW)) u_sel (
    .level_i (raw_level),
    .gap_i   (gap),
    .level_o (level_out),
    .err_o   (bubble_err)
  );
endmodule

// File: rtl/tcd_thermo_decoder_chk.sv
module tcd_thermo_decoder_chk #(
  parameter int W  = 12,
  parameter int OW = 4
) (
  input logic [W-1:0]  therm_in,
  input logic [OW-1:0] level_out,
  input logic          bubble_err
);
  logic [W:0] wide;
  logic [W:0] wide_inc;
  logic       is_mask;

  // A word of the form 2^k - 1 shares no set bit with its successor.
  always_comb begin
    wide     = {1'b0, therm_in};
    wide_inc = wide + 1'b1;
    is_mask  = ((wide & wide_inc) == '0);
  end

  always_comb begin
    // R1: valid word reports its population count
    a_r1_level_count: assert (!is_mask || (32'(level_out) == $countones(therm_in)));
    // R2: valid words never flag
    a_r2_valid_clean: assert (!is_mask || !bubble_err);
    // R3: corrupt words always flag
    a_r3_bubble_flag: assert (is_mask || bubble_err);
    // R5: flag forces full scale
    a_r5_full_scale: assert (!bubble_err || (32'(level_out) == W));
    // R6: never beyond full scale
    a_r6_no_overrange: assert (32'(level_out) <= W);
  end
endmodule

bind tcd_thermo_decoder tcd_thermo_decoder_chk #(.W(W), .OW(OW)) u_chk (
  .therm_in   (therm_in),
  .level_out  (level_out),
  .bubble_err (bubble_err)
);

// File: tb/tcd_thermo_decoder_bench.sv
`timescale 1ns/1ps
module tcd_thermo_decoder_bench;
  localparam int PERIOD   = 10;
  localparam int W        = 12;
  localparam int NVEC     = 18;
  localparam int WD_LIMIT = 20000;

  // {input word, expected level, expected flag}
  localparam logic [16:0] VEC [NVEC] = '{
    {12'h000, 4'd0,  1'b0},
    {12'h001, 4'd1,  1'b0},
    {12'h003, 4'd2,  1'b0},
    {12'h007, 4'd3,  1'b0},
    {12'h00F, 4'd4,  1'b0},
    {12'h01F, 4'd5,  1'b0},
    {12'h03F, 4'd6,  1'b0},
    {12'h07F, 4'd7,  1'b0},
    {12'h0FF, 4'd8,  1'b0},
    {12'h1FF, 4'd9,  1'b0},
    {12'h3FF, 4'd10, 1'b0},
    {12'h7FF, 4'd11, 1'b0},
    {12'hFFF, 4'd12, 1'b0},
    {12'h010, 4'd12, 1'b1},
    {12'h8FF, 4'd12, 1'b1},
    {12'hF4F, 4'd12, 1'b1},
    {12'hFF0, 4'd12, 1'b1},
    {12'h7FE, 4'd12, 1'b1}
  };

  logic        clk;
  logic [11:0] therm_in;
  logic [3:0]  level_out;
  logic        bubble_err;
  int          n_vec;
  int          n_bad;
  int          cycles;
  bit          done;

  tcd_thermo_decoder u_tcd_thermo_decoder (
    .therm_in   (therm_in),
    .level_out  (level_out),
    .bubble_err (bubble_err)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_LIMIT && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=%0d", cycles, WD_LIMIT);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic check(input logic [11:0] w, input logic [3:0] exp_l,
                       input logic exp_e, input string req);
    therm_in = w;
    #1;
    n_vec++;
    if (level_out !== exp_l || bubble_err !== exp_e) begin
      n_bad++;
      $display("FAIL %s in=%03h: actual level=%0d err=%b expected level=%0d err=%b",
               req, w, level_out, bubble_err, exp_l, exp_e);
    end
  endtask

  function automatic logic ref_bad(input logic [11:0] w);
    for (int i = 0; i < W - 1; i++) if (w[i+1] && !w[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [3:0] ref_level(input logic [11:0] w);
    int c = 0;
    if (ref_bad(w)) return 4'd12;
    for (int i = 0; i < W; i++) c += int'(w[i]);
    return 4'(c);
  endfunction

  initial begin
    n_vec = 0; n_bad = 0; cycles = 0; done = 0;
    therm_in = '0;
    @(negedge clk);
    // Idle state: all-zero word (R1, R2)
    check(12'h000, 4'd0, 1'b0, "R1/R2 idle");

    // Table walk: valid levels (R1, R2) and near-miss corrupt words (R3, R4, R5)
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      check(VEC[k][16:5], VEC[k][4:1], VEC[k][0],
            VEC[k][0] ? "R3/R5 table" : "R1/R2 table");
    end

    // R4: every lone bit above bit 0
    for (int b = 1; b < W; b++) begin
      @(negedge clk);
      check(12'(1) << b, 4'd12, 1'b1, "R4 lone bit");
    end

    // R7: several input changes between two clock edges, no edge needed
    @(posedge clk); #1;
    check(12'h03F, 4'd6,  1'b0, "R7 no clock");
    check(12'hA00, 4'd12, 1'b1, "R7 no clock");
    check(12'h001, 4'd1,  1'b0, "R7 no clock");

    // Exhaustive sweep against reference (R1, R2, R3, R5, R6)
    for (int v = 0; v < 4096; v++) begin
      @(negedge clk);
      check(12'(v), ref_level(12'(v)), ref_bad(12'(v)), "R1/R3/R5 sweep");
      if (level_out > 4'd12) begin
        n_bad++;
        $display("FAIL R6 in=%03h: actual level=%0d expected<=12", 12'(v), level_out);
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule